// File: doc/BRIEF.md
# 8-bit Bit-Manipulation Unit

This unit adds a set of data operations to a small accumulator-style processor. Each operation takes an operand byte, an incoming carry and a 4-bit operation code. It produces a result byte and new negative (N), zero (Z) and carry (C) flags. All the work is combinational. The result and the flags are captured in output registers on the rising clock edge when the valid strobe is high, so every operation completes in a single cycle.

The operations are:

- rotates that bypass the carry,
- an arithmetic right shift,
- a half (nibble) swap,
- two's-complement negation,
- a population count,
- a search for the most significant 1 bit,
- a search for the most significant 0 bit,
- a full bit reversal.

The unit also drives two unsigned branch conditions, "below" and "above", from the flags it holds. Instruction decode, addressing and program flow belong to the surrounding processor.

The data width is a parameter whose default is 8. A second parameter picks the circuit used for the top-bit searches. Both circuits give the same results.

Top module: `bitop_unit`

## Requirements
- R1: Op code 0 (direct rotate left) moves every bit up one place and puts bit 7 into bit 0. C takes the old bit 7, and carry_i has no effect on the result.
- R2: Op code 1 (direct rotate right) moves every bit down one place and puts bit 0 into bit 7. C takes the old bit 0, and carry_i has no effect on the result.
- R3: Op code 2 (arithmetic shift right) shifts the operand down one place and keeps bit 7 at its old value. C takes the old bit 0.
- R4: Op code 3 (half swap) returns the operand with bits 7..4 and bits 3..0 exchanged.
- R5: Op code 4 (negate) returns the two's complement of the operand, modulo 256.
- R6: Op code 5 (population count) returns the number of 1 bits in the operand, from 0 to 8.
- R7: Op code 6 (top-set search) returns the position (0..7) of the most significant 1 bit and clears Z. If the operand is zero, it returns 0 and sets Z.
- R8: Op code 7 (top-clear search) returns the position of the most significant 0 bit and clears Z. If the operand is all ones, it returns 0 and sets Z.
- R9: Op code 8 (reverse) swaps bit i with bit 7-i for every i.
- R10: N equals bit 7 of the result for every operation. Outside op codes 6 and 7, Z is set exactly when the result is zero. For op codes 3 to 8, C takes the value of carry_i.
- R11: below_o is high when C=0 or Z=1. above_o is high when C=1 and Z=0. Exactly one of the two is high at any time.
- R12: The outputs change only at a rising edge where valid_i is high and op_i is 0 to 8. When valid_i is low, or op_i is 9 to 15, all outputs hold their values.
- R13: While rst_n is low, the result is 0 and N, Z and C are all 0, which makes below_o high and above_o low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Captures an operation at this edge |
| op_i | input | 4 | Operation code (0..8; 9..15 are reserved) |
| operand_i | input | DATA_W | Operand byte |
| carry_i | input | 1 | Incoming carry flag |
| result_o | output | DATA_W | Registered result |
| flag_n_o | output | 1 | Registered negative flag |
| flag_z_o | output | 1 | Registered zero / not-found flag |
| flag_c_o | output | 1 | Registered carry flag |
| below_o | output | 1 | Unsigned less-than branch condition |
| above_o | output | 1 | Unsigned greater-than branch condition |

## Verification
The clocked properties assume that valid_i, op_i, operand_i and carry_i are held steady around each rising edge. The bench meets this by changing them only at falling edges. They also assume that op_i holds a defined value whenever valid_i is high, which the bench ensures because it never leaves an input undriven after reset. The hold property covers reserved op codes, so the bench drives codes 9 to 15 with valid_i high as well as idle cycles with the operand changing.

// File: rtl/bitop_pkg.sv
package bitop_pkg;
   typedef enum logic [3:0] {
      OP_ROTL   = 4'd0,
      OP_ROTR   = 4'd1,
      OP_SHRA   = 4'd2,
      OP_HSWAP  = 4'd3,
      OP_NEGATE = 4'd4,
      OP_POPCNT = 4'd5,
      OP_TOPSET = 4'd6,
      OP_TOPCLR = 4'd7,
      OP_REVERSE= 4'd8
   } bitop_e;

   localparam logic [3:0] OP_HIGHEST = 4'd8;

   localparam int SCAN_PRIORITY = 0;
   localparam int SCAN_ONEHOT   = 1;
endpackage

// File: rtl/bitop_perm.sv
module bitop_perm
   import bitop_pkg::*;
#(
   parameter int W = 8
) (
   input  logic [W-1:0] a,
   input  bitop_e       op,
   output logic [W-1:0] y,
   output logic         spill
);
   localparam int HALF = W / 2;

   logic [W-1:0] mirrored;

   for (genvar i = 0; i < W; i++) begin : g_mirror
      assign mirrored[i] = a[W-1-i];
   end

   always_comb begin
      y     = a;
      spill = 1'b0;
      case (op)
         OP_ROTL: begin
            y     = {a[W-2:0], a[W-1]};
            spill = a[W-1];
         end
         OP_ROTR: begin
            y     = {a[0], a[W-1:1]};
            spill = a[0];
         end
         OP_SHRA: begin
            y     = {a[W-1], a[W-1:1]};
            spill = a[0];
         end
         OP_HSWAP:   y = {a[HALF-1:0], a[W-1:HALF]};
         OP_REVERSE: y = mirrored;
         default: ;
      endcase
   end
endmodule

// File: rtl/bitop_popcnt.sv
module bitop_popcnt #(
   parameter int W = 8
) (
   input  logic [W-1:0]         a,
   output logic [$clog2(W+1)-1:0] count
);
   localparam int CW = $clog2(W + 1);

   always_comb begin
      count = '0;
      for (int i = 0; i < W; i++) begin
         count = count + CW'(a[i]);
      end
   end
endmodule

// File: rtl/bitop_topbit.sv
module bitop_topbit
   import bitop_pkg::*;
#(
   parameter int W     = 8,
   parameter int STYLE = SCAN_ONEHOT
) (
   input  logic [W-1:0]         v,
   output logic [$clog2(W)-1:0] idx,
   output logic                 found
);
   localparam int IW = $clog2(W);

   assign found = |v;

   if (STYLE == SCAN_PRIORITY) begin : g_priority
      always_comb begin
         idx = '0;
         for (int i = 0; i < W; i++) begin
            if (v[i]) idx = IW'(i);
         end
      end
   end else begin : g_onehot
      logic [W-1:0] above;
      logic [W-1:0] hot;
      for (genvar i = 0; i < W; i++) begin : g_mask
         if (i == W - 1) begin : g_top
            assign above[i] = 1'b0;
         end else begin : g_rest
            assign above[i] = |v[W-1:i+1];
         end
      end
      assign hot = v & ~above;
      always_comb begin
         idx = '0;
         for (int i = 0; i < W; i++) begin
            if (hot[i]) idx = idx | IW'(i);
         end
      end
   end
endmodule

// File: rtl/bitop_cond.sv
module bitop_cond (
   input  logic clk,
   input  logic rst_n,
   input  logic c,
   input  logic z,
   output logic below,
   output logic above
);
   assign below = ~c | z;
   assign above = c & ~z;

   assert_cond_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot({below, above}));
endmodule

// File: rtl/bitop_unit.sv
module bitop_unit
   import bitop_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter int SCAN_STYLE = SCAN_ONEHOT
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              valid_i,
   input  logic [3:0]        op_i,
   input  logic [DATA_W-1:0] operand_i,
   input  logic              carry_i,
   output logic [DATA_W-1:0] result_o,
   output logic              flag_n_o,
   output logic              flag_z_o,
   output logic              flag_c_o,
   output logic              below_o,
   output logic              above_o
);
   localparam int CW = $clog2(DATA_W + 1);
   localparam int IW = $clog2(DATA_W);

   if (DATA_W < 4 || (DATA_W % 2) != 0) begin : g_bad_width
      $error("bitop_unit: DATA_W must be even and at least 4");
   end
   if (SCAN_STYLE != SCAN_PRIORITY && SCAN_STYLE != SCAN_ONEHOT) begin : g_bad_style
      $error("bitop_unit: unknown SCAN_STYLE");
   end

   bitop_e            op_e;
   logic [DATA_W-1:0] perm_y;
   logic              perm_spill;
   logic [CW-1:0]     ones;
   logic [IW-1:0]     set_idx, clr_idx;
   logic              set_hit, clr_hit;
   logic [DATA_W-1:0] nx_res;
   logic              nx_n, nx_z, nx_c;
   logic              searching, hit;
   logic              take;

   assign op_e = bitop_e'(op_i);

   bitop_perm #(.W(DATA_W)) u_perm (
      .a     (operand_i),
      .op    (op_e),
      .y     (perm_y),
      .spill (perm_spill)
   );

   bitop_popcnt #(.W(DATA_W)) u_popcnt (
      .a     (operand_i),
      .count (ones)
   );

   bitop_topbit #(.W(DATA_W), .STYLE(SCAN_STYLE)) u_top_set (
      .v     (operand_i),
      .idx   (set_idx),
      .found (set_hit)
   );

   bitop_topbit #(.W(DATA_W), .STYLE(SCAN_STYLE)) u_top_clr (
      .v     (~operand_i),
      .idx   (clr_idx),
      .found (clr_hit)
   );

   always_comb begin
      nx_res    = operand_i;
      nx_c      = carry_i;
      searching = 1'b0;
      hit       = 1'b1;
      case (op_e)
         OP_ROTL, OP_ROTR, OP_SHRA: begin
            nx_res = perm_y;
            nx_c   = perm_spill;
         end
         OP_HSWAP, OP_REVERSE: nx_res = perm_y;
         OP_NEGATE: nx_res = '0 - operand_i;
         OP_POPCNT: nx_res = DATA_W'(ones);
         OP_TOPSET: begin
            searching = 1'b1;
            hit       = set_hit;
            nx_res    = set_hit ? DATA_W'(set_idx) : '0;
         end
         OP_TOPCLR: begin
            searching = 1'b1;
            hit       = clr_hit;
            nx_res    = clr_hit ? DATA_W'(clr_idx) : '0;
         end
         default: ;
      endcase
      nx_n = nx_res[DATA_W-1];
      nx_z = searching ? ~hit : (nx_res == '0);
   end

   assign take = valid_i && (op_i <= OP_HIGHEST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         result_o <= '0;
         flag_n_o <= 1'b0;
         flag_z_o <= 1'b0;
         flag_c_o <= 1'b0;
      end else if (take) begin
         result_o <= nx_res;
         flag_n_o <= nx_n;
         flag_z_o <= nx_z;
         flag_c_o <= nx_c;
      end
   end

   bitop_cond u_cond (
      .clk   (clk),
      .rst_n (rst_n),
      .c     (flag_c_o),
      .z     (flag_z_o),
      .below (below_o),
      .above (above_o)
   );

   assert_rotl_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_i && op_i == 4'd0) |=>
         (result_o[0] == $past(operand_i[DATA_W-1])) && (flag_c_o == $past(operand_i[DATA_W-1])));

   assert_rotr_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_i && op_i == 4'd1) |=>
         (result_o[DATA_W-1] == $past(operand_i[0])) && (flag_c_o == $past(operand_i[0])));

   assert_shra_sign_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_i && op_i == 4'd2) |=>
         (result_o[DATA_W-1] == $past(operand_i[DATA_W-1])) && (flag_c_o == $past(operand_i[0])));

   assert_hswap_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_i && op_i == 4'd3) |=>
         (result_o[DATA_W/2-1:0] == $past(operand_i[DATA_W-1:DATA_W/2])));

   assert_negate_sum_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_i && op_i == 4'd4) |=> (DATA_W'(result_o + $past(operand_i)) == '0));

   assert_popcnt_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_i && op_i == 4'd5) |=> (result_o == DATA_W'($countones($past(operand_i)))));

   assert_topset_found_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_i && op_i == 4'd6 && operand_i != '0) |=>
         ((($past(operand_i)) >> result_o) == DATA_W'(1)) && !flag_z_o);

   assert_topset_none_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_i && op_i == 4'd6 && operand_i == '0) |=> (flag_z_o && result_o == '0));

   assert_topclr_none_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_i && op_i == 4'd7 && operand_i == '1) |=> (flag_z_o && result_o == '0));

   assert_reverse_ends_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_i && op_i == 4'd8) |=>
         (result_o[0] == $past(operand_i[DATA_W-1])) && (result_o[DATA_W-1] == $past(operand_i[0])));

   assert_carry_pass_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_i && op_i >= 4'd3 && op_i <= 4'd8) |=> (flag_c_o == $past(carry_i)));

   assert_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !(valid_i && op_i <= 4'd8) |=>
         ($stable(result_o) && $stable(flag_n_o) && $stable(flag_z_o) && $stable(flag_c_o)));
endmodule

// File: tb/bitop_unit_test.sv
module bitop_unit_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       valid_i = 1'b0;
   logic [3:0] op_i = 4'd0;
   logic [7:0] operand_i = 8'd0;
   logic       carry_i = 1'b0;
   logic [7:0] result_o;
   logic       flag_n_o, flag_z_o, flag_c_o, below_o, above_o;

   int total = 0;
   int failed = 0;
   bit done = 1'b0;
   logic [10:0] last_exp = 11'd0;

   always #10 clk = ~clk;

   bitop_unit uut (
      .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .op_i(op_i),
      .operand_i(operand_i), .carry_i(carry_i), .result_o(result_o),
      .flag_n_o(flag_n_o), .flag_z_o(flag_z_o), .flag_c_o(flag_c_o),
      .below_o(below_o), .above_o(above_o)
   );

   // Expected {result, N, Z, C} worked out from the requirements.
   function automatic logic [10:0] model(input logic [3:0] op, input logic [7:0] a, input logic cin);
      logic [7:0] r;
      logic c, z, found, want;
      r = a; c = cin; found = 1'b0; want = 1'b0;
      case (op)
         4'd0: begin r = (a << 1) | (a >> 7); c = a[7]; end
         4'd1: begin r = (a >> 1) | (a << 7); c = a[0]; end
         4'd2: begin r = $signed(a) >>> 1; c = a[0]; end
         4'd3: r = {a[3:0], a[7:4]};
         4'd4: r = 8'd0 - a;
         4'd5: begin
            r = 8'd0;
            for (int i = 0; i < 8; i++) r = r + {7'd0, a[i]};
         end
         4'd6, 4'd7: begin
            want = (op == 4'd6);
            r = 8'd0;
            for (int i = 7; i >= 0; i--) begin
               if (!found && a[i] == want) begin r = 8'(i); found = 1'b1; end
            end
         end
         4'd8: for (int i = 0; i < 8; i++) r[i] = a[7-i];
         default: ;
      endcase
      z = (op == 4'd6 || op == 4'd7) ? !found : (r == 8'd0);
      return {r, r[7], z, c};
   endfunction

   task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
      total++;
      if (got !== exp) begin
         failed++;
         $display("FAIL %s: actual %h expected %h", tag, got, exp);
      end
   endtask

   task automatic check_cond(input logic [10:0] exp);
      logic lt, gt;
      lt = !exp[0] || exp[1];
      gt = exp[0] && !exp[1];
      check("R11 branch conditions", {14'd0, below_o, above_o}, {14'd0, lt, gt});
   endtask

   // Drive one operation at a falling edge, capture at the rising edge,
   // then compare at the next falling edge.
   task automatic run_op(input string tag, input logic [3:0] op, input logic [7:0] a, input logic cin);
      logic [10:0] exp;
      @(negedge clk);
      valid_i = 1'b1; op_i = op; operand_i = a; carry_i = cin;
      @(negedge clk);
      valid_i = 1'b0;
      exp = (op <= 4'd8) ? model(op, a, cin) : last_exp;
      last_exp = exp;
      check(tag, {5'd0, result_o, flag_n_o, flag_z_o, flag_c_o}, {5'd0, exp});
      check_cond(exp);
   endtask

   task automatic t_reset();
      check("R13 reset outputs", {5'd0, result_o, flag_n_o, flag_z_o, flag_c_o}, 16'd0);
      check("R13 reset branch", {14'd0, below_o, above_o}, 16'b10);
   endtask

   task automatic t_rotates();
      run_op("R1 rotl 0x81 c0", 4'd0, 8'h81, 1'b0);
      run_op("R1 rotl 0x81 c1 ignored", 4'd0, 8'h81, 1'b1);
      run_op("R1 rotl 0x40 c1", 4'd0, 8'h40, 1'b1);
      run_op("R2 rotr 0x01 c0", 4'd1, 8'h01, 1'b0);
      run_op("R2 rotr 0x02 c1 ignored", 4'd1, 8'h02, 1'b1);
      run_op("R2 rotr 0x00", 4'd1, 8'h00, 1'b1);
   endtask

   task automatic t_shift_swap();
      run_op("R3 shra 0x83", 4'd2, 8'h83, 1'b0);
      run_op("R3 shra 0x7E", 4'd2, 8'h7E, 1'b1);
      run_op("R3 shra 0x01", 4'd2, 8'h01, 1'b0);
      run_op("R4 hswap 0xA5", 4'd3, 8'hA5, 1'b1);
      run_op("R4 hswap 0x1F", 4'd3, 8'h1F, 1'b0);
   endtask

   task automatic t_negate();
      run_op("R5 negate 0x01", 4'd4, 8'h01, 1'b0);
      run_op("R5 negate 0x80", 4'd4, 8'h80, 1'b1);
      run_op("R5 negate 0x00", 4'd4, 8'h00, 1'b1);
   endtask

   task automatic t_popcount();
      run_op("R6 popcnt 0x00", 4'd5, 8'h00, 1'b0);
      run_op("R6 popcnt 0xFF", 4'd5, 8'hFF, 1'b1);
      run_op("R6 popcnt 0x96", 4'd5, 8'h96, 1'b0);
   endtask

   task automatic t_top_set();
      run_op("R7 topset 0x00 none", 4'd6, 8'h00, 1'b1);
      run_op("R7 topset 0x01 bit0", 4'd6, 8'h01, 1'b0);
      run_op("R7 topset 0x2C", 4'd6, 8'h2C, 1'b1);
      run_op("R7 topset 0x80", 4'd6, 8'h80, 1'b0);
   endtask

   task automatic t_top_clr();
      run_op("R8 topclr 0xFF none", 4'd7, 8'hFF, 1'b1);
      run_op("R8 topclr 0xFE bit0", 4'd7, 8'hFE, 1'b1);
      run_op("R8 topclr 0xC7", 4'd7, 8'hC7, 1'b0);
      run_op("R8 topclr 0x00", 4'd7, 8'h00, 1'b0);
   endtask

   task automatic t_reverse();
      run_op("R9 reverse 0x01", 4'd8, 8'h01, 1'b0);
      run_op("R9 reverse 0xB4", 4'd8, 8'hB4, 1'b1);
   endtask

   task automatic t_flags();
      run_op("R10 negative result flags", 4'd3, 8'h0F, 1'b1);
      run_op("R10 zero result flags", 4'd8, 8'h00, 1'b0);
   endtask

   task automatic t_hold();
      run_op("R12 setup", 4'd3, 8'h5C, 1'b1);
      @(negedge clk);
      valid_i = 1'b0; op_i = 4'd4; operand_i = 8'h33; carry_i = 1'b0;
      repeat (3) @(negedge clk);
      check("R12 idle hold", {5'd0, result_o, flag_n_o, flag_z_o, flag_c_o}, {5'd0, last_exp});
      for (int k = 9; k < 16; k++) begin
         run_op("R12 reserved op ignored", 4'(k), 8'hE1, 1'b0);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      t_rotates();
      t_shift_swap();
      t_negate();
      t_popcount();
      t_top_set();
      t_top_clr();
      t_reverse();
      t_flags();
      t_hold();
      done = 1'b1;
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         total++;
         failed++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", total - failed, total);
         $finish;
      end
   end
endmodule